// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a watchdog with a small synchronous register port. Software loads a timeout value, clears a halt bit and then has to keep rewriting the reload register. If it stops doing so, a down-counter runs out. A prescaler sets the counter's step, one tick every `TICK_CYCLES` clock cycles.

The first expiry only raises a timeout flag. It can also request a system-management interrupt, and then the counter restarts from the timeout value. If a second expiry follows without an intervening reload, the block sets second-timeout and boot status and issues a one-cycle reboot pulse. A strap input or a no-reboot input can suppress that pulse. Two mailbox registers let software signal the block, and the block holds message bytes plus a software interrupt byte.

The port moves one 16-bit slot per access. `addr_i` is the slot index and `be_i` enables the low byte (bit 0) and the high byte (bit 1). A read returns the slot on `rdata_o` one cycle after `rd_en_i`. Slots 11 to 15 read as zero and ignore writes. Write-only effects are reported through the SMI and reboot request pulses. Interrupt routing and platform reset sit outside this block.

Top module: `wdt_two_strike`

## Requirements
- R1: After reset, the slots read as follows: timeout value (slot 1) is 4, control 2 (slot 5) is 0x0008 and software interrupt (slot 10) is 0x0003. Every other slot reads 0, the timer is stopped, and `smi_o` and `reboot_o` are low.
- R2: The timer may run only when halt (bit 11 of control 1, slot 4) is clear and the timeout value is greater than 1. With a value of 0 or 1 the timer never starts.
- R3: Any write to the reload register (slot 0) clears the consecutive-expiry count. If the timer may run, the write restarts the counter from the timeout value. Otherwise the written bytes are stored and read back.
- R4: After a start, the counter expires after (timeout value × `TICK_CYCLES`) cycles. A first expiry sets timeout status (bit 3 of status 1, slot 2), pulses `smi_o` when `smi_en_i` is high, and restarts the counter.
- R5: A second consecutive expiry sets second-timeout (bit 1) and boot (bit 2) in status 2 (slot 3). With `strap_quiet_i` and `no_reboot_i` both low, it pulses `reboot_o`, issues no SMI and stops the timer, and the reload register then reads 0.
- R6: If either `strap_quiet_i` or `no_reboot_i` is high at the second expiry, no reboot occurs. The expiry behaves like a first one (SMI when enabled, restart), and the timer keeps running.
- R7: Lock (bit 12 of control 1) is sticky. Once it is set, writes cannot clear it, and only reset clears it.
- R8: Every write to control 1 re-evaluates the run condition. When the timer may run, the write restarts the counter. Otherwise it stops the timer, and the reload register then reads its stored value.
- R9: A low-byte write to mailbox-in (slot 6) stores the byte, sets bit 1 of status 1 and pulses `smi_o` whatever `smi_en_i` is. A low-byte write to mailbox-out (slot 7) stores the byte, sets bit 2 of status 1 and does not pulse `smi_o`.
- R10: The status registers are write-one-to-clear: a 1 clears its bit and a 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R11: While the timer runs, the reload register reads the live remaining tick count in bits [CNT_W-1:0]. The bits above come from the stored reload value.
- R12: `smi_o` and `reboot_o` are single-cycle pulses per cause.
- R13: Byte enables select the lanes written. Byte-wide registers (slots 6 to 10) take only the low lane. Slots 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read strobe; data on `rdata_o` next cycle |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 4 | Slot index |
| be_i | input | 2 | Byte lane enables (bit 0 low byte) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| smi_en_i | input | 1 | Allows expiry SMI requests |
| strap_quiet_i | input | 1 | Strap that suppresses reboot |
| no_reboot_i | input | 1 | Suppresses reboot |
| smi_o | output | 1 | SMI request pulse |
| reboot_o | output | 1 | Reboot request pulse |

## Verification
The bench builds the block with `TICK_CYCLES` = 4 and `CNT_W` = 10. A timeout of 3 ticks therefore expires in 12 cycles, and the full first-strike, second-strike and blocked-reboot sequences each fit in a few dozen cycles, so every expiry edge can be checked to the cycle. A timeout value of 0x0403 brings the split between the counter field and the stored upper bits of the live reload read within reach, because only its low 10 bits are counted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int REG_W  = 16;
  localparam int SLOT_W = 4;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_RELOAD   = 4'd0,
    SLOT_TOVAL    = 4'd1,
    SLOT_STAT1    = 4'd2,
    SLOT_STAT2    = 4'd3,
    SLOT_CTRL1    = 4'd4,
    SLOT_CTRL2    = 4'd5,
    SLOT_MBOX_IN  = 4'd6,
    SLOT_MBOX_OUT = 4'd7,
    SLOT_MSG_A    = 4'd8,
    SLOT_MSG_B    = 4'd9,
    SLOT_SWIRQ    = 4'd10
  } slot_e;

  localparam int HALT_BIT  = 11;
  localparam int LOCK_BIT  = 12;
  localparam int S1_SWSMI  = 1;
  localparam int S1_DOUT   = 2;
  localparam int S1_TMO    = 3;
  localparam int S2_SECOND = 1;
  localparam int S2_BOOT   = 2;

  localparam logic [REG_W-1:0] CTRL1_MASK = REG_W'((1 << HALT_BIT) | (1 << LOCK_BIT));
  localparam logic [REG_W-1:0] STAT1_MASK = REG_W'((1 << S1_SWSMI) | (1 << S1_DOUT) | (1 << S1_TMO));
  localparam logic [REG_W-1:0] STAT2_MASK = REG_W'((1 << S2_SECOND) | (1 << S2_BOOT));

  localparam logic [REG_W-1:0] TOVAL_RST = 16'h0004;
  localparam logic [REG_W-1:0] CTRL2_RST = 16'h0008;
  localparam logic [7:0]       SWIRQ_RST = 8'h03;

  typedef struct packed {
    logic expire;
    logic second;
    logic reboot;
  } exp_evt_t;

  function automatic logic [REG_W-1:0] merge_bytes(input logic [REG_W-1:0] old_v,
                                                   input logic [REG_W-1:0] new_v,
                                                   input logic [1:0]       be);
    merge_bytes = {be[1] ? new_v[15:8] : old_v[15:8],
                   be[0] ? new_v[7:0]  : old_v[7:0]};
  endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int TICK_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);

  generate
    if (TICK_CYCLES <= 1) begin : g_every_cycle
      logic unused_clr;
      assign unused_clr = clear_i;
      assign tick_o     = run_i;
    end else begin : g_prescale
      localparam int PW = $clog2(TICK_CYCLES);
      localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

      logic [PW-1:0] presc_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  presc_q <= '0;
        else if (!run_i || clear_i)   presc_q <= '0;
        else if (presc_q == LAST)     presc_q <= '0;
        else                          presc_q <= presc_q + PW'(1);
      end

      assign tick_o = run_i && !clear_i && (presc_q == LAST);

      p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/wdt_expiry_ctrl.sv
module wdt_expiry_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             clr_strike_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             block_reboot_i,
  input  logic             smi_en_i,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o,
  output exp_evt_t         evt_o,
  output logic             smi_req_o,
  output logic             reboot_o
);

  logic             running_q;
  logic [CNT_W-1:0] cnt_q;
  logic             strike_q;
  logic             reboot_q;
  logic             expire;
  logic             second;
  logic             do_reboot;

  // software commands take priority over an expiry in the same cycle
  assign expire    = running_q && tick_i && (cnt_q <= CNT_W'(1)) && !load_i && !stop_i;
  assign second    = expire && strike_q;
  assign do_reboot = second && !block_reboot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      strike_q  <= 1'b0;
      reboot_q  <= 1'b0;
    end else begin
      reboot_q <= do_reboot;

      if (stop_i)         running_q <= 1'b0;
      else if (load_i)    running_q <= 1'b1;
      else if (do_reboot) running_q <= 1'b0;

      if (load_i)                     cnt_q <= load_val_i;
      else if (do_reboot)             cnt_q <= '0;
      else if (expire)                cnt_q <= load_val_i;
      else if (running_q && tick_i)   cnt_q <= cnt_q - CNT_W'(1);

      if (clr_strike_i) strike_q <= 1'b0;
      else if (expire)  strike_q <= ~strike_q;
    end
  end

  assign running_o    = running_q;
  assign cnt_o        = cnt_q;
  assign evt_o.expire = expire;
  assign evt_o.second = second;
  assign evt_o.reboot = do_reboot;
  assign smi_req_o    = expire && !do_reboot && smi_en_i;
  assign reboot_o     = reboot_q;

  p_reboot_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_q |=> !reboot_q);

  p_reboot_stops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_q |-> !running_q);

  p_strike_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_strike_i |=> !strike_q);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              running_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  exp_evt_t          evt_i,
  output logic              load_o,
  output logic              stop_o,
  output logic              clr_strike_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              mbox_in_wr_o
);

  localparam logic [REG_W-1:0] CNT_MASK = REG_W'((1 << CNT_W) - 1);

  logic [REG_W-1:0] reload_q, toval_q, stat1_q, stat2_q, ctrl1_q, ctrl2_q;
  logic [7:0]       mbox_in_q, mbox_out_q, msg_a_q, msg_b_q, swirq_q;

  slot_e            sel;
  logic             any_be;
  logic             wr_reload, wr_toval, wr_stat1, wr_stat2, wr_ctrl1, wr_ctrl2;
  logic             wr_mbox_in, wr_mbox_out, wr_msg_a, wr_msg_b, wr_swirq;
  logic [REG_W-1:0] wr_merged_reload, ctrl1_new;
  logic             can_run_now, can_run_new;
  logic [REG_W-1:0] s1_set, s1_clr, s2_set, s2_clr;
  logic [REG_W-1:0] rd_val;

  assign sel    = slot_e'(addr_i);
  assign any_be = |be_i;

  always_comb begin
    wr_reload   = wr_en_i && any_be && (sel == SLOT_RELOAD);
    wr_toval    = wr_en_i && any_be && (sel == SLOT_TOVAL);
    wr_stat1    = wr_en_i && any_be && (sel == SLOT_STAT1);
    wr_stat2    = wr_en_i && any_be && (sel == SLOT_STAT2);
    wr_ctrl1    = wr_en_i && any_be && (sel == SLOT_CTRL1);
    wr_ctrl2    = wr_en_i && any_be && (sel == SLOT_CTRL2);
    wr_mbox_in  = wr_en_i && be_i[0] && (sel == SLOT_MBOX_IN);
    wr_mbox_out = wr_en_i && be_i[0] && (sel == SLOT_MBOX_OUT);
    wr_msg_a    = wr_en_i && be_i[0] && (sel == SLOT_MSG_A);
    wr_msg_b    = wr_en_i && be_i[0] && (sel == SLOT_MSG_B);
    wr_swirq    = wr_en_i && be_i[0] && (sel == SLOT_SWIRQ);
  end

  assign wr_merged_reload = merge_bytes(reload_q, wdata_i, be_i);
  assign ctrl1_new   = (merge_bytes(ctrl1_q, wdata_i, be_i) & CTRL1_MASK)
                     | (ctrl1_q & REG_W'(1 << LOCK_BIT));
  assign can_run_now = !ctrl1_q[HALT_BIT]   && (toval_q > REG_W'(1));
  assign can_run_new = !ctrl1_new[HALT_BIT] && (toval_q > REG_W'(1));

  assign load_o       = (wr_reload && can_run_now) || (wr_ctrl1 && can_run_new);
  assign stop_o       = wr_ctrl1 && !can_run_new;
  assign clr_strike_o = wr_reload;
  assign load_val_o   = toval_q[CNT_W-1:0];
  assign mbox_in_wr_o = wr_mbox_in;

  always_comb begin
    s1_set = '0;
    s1_set[S1_SWSMI] = wr_mbox_in;
    s1_set[S1_DOUT]  = wr_mbox_out;
    s1_set[S1_TMO]   = evt_i.expire;
    s2_set = '0;
    s2_set[S2_SECOND] = evt_i.second;
    s2_set[S2_BOOT]   = evt_i.second;
    s1_clr = wr_stat1 ? merge_bytes('0, wdata_i, be_i) : '0;
    s2_clr = wr_stat2 ? merge_bytes('0, wdata_i, be_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q   <= '0;
      toval_q    <= TOVAL_RST;
      stat1_q    <= '0;
      stat2_q    <= '0;
      ctrl1_q    <= '0;
      ctrl2_q    <= CTRL2_RST;
      mbox_in_q  <= '0;
      mbox_out_q <= '0;
      msg_a_q    <= '0;
      msg_b_q    <= '0;
      swirq_q    <= SWIRQ_RST;
    end else begin
      if (load_o)            reload_q <= toval_q;
      else if (wr_reload)    reload_q <= wr_merged_reload;
      else if (evt_i.reboot) reload_q <= '0;
      else if (evt_i.expire) reload_q <= toval_q;

      if (wr_toval)    toval_q    <= merge_bytes(toval_q, wdata_i, be_i);
      if (wr_ctrl1)    ctrl1_q    <= ctrl1_new;
      if (wr_ctrl2)    ctrl2_q    <= merge_bytes(ctrl2_q, wdata_i, be_i);
      if (wr_mbox_in)  mbox_in_q  <= wdata_i[7:0];
      if (wr_mbox_out) mbox_out_q <= wdata_i[7:0];
      if (wr_msg_a)    msg_a_q    <= wdata_i[7:0];
      if (wr_msg_b)    msg_b_q    <= wdata_i[7:0];
      if (wr_swirq)    swirq_q    <= wdata_i[7:0];

      // set wins over a same-cycle clear
      stat1_q <= ((stat1_q & ~s1_clr) | s1_set) & STAT1_MASK;
      stat2_q <= ((stat2_q & ~s2_clr) | s2_set) & STAT2_MASK;
    end
  end

  always_comb begin
    case (sel)
      SLOT_RELOAD:   rd_val = running_i ? ((reload_q & ~CNT_MASK) | REG_W'(cnt_i)) : reload_q;
      SLOT_TOVAL:    rd_val = toval_q;
      SLOT_STAT1:    rd_val = stat1_q;
      SLOT_STAT2:    rd_val = stat2_q;
      SLOT_CTRL1:    rd_val = ctrl1_q;
      SLOT_CTRL2:    rd_val = ctrl2_q;
      SLOT_MBOX_IN:  rd_val = {8'h00, mbox_in_q};
      SLOT_MBOX_OUT: rd_val = {8'h00, mbox_out_q};
      SLOT_MSG_A:    rd_val = {8'h00, msg_a_q};
      SLOT_MSG_B:    rd_val = {8'h00, msg_b_q};
      SLOT_SWIRQ:    rd_val = {8'h00, swirq_q};
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  p_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl1_q[LOCK_BIT] |=> ctrl1_q[LOCK_BIT]);

  p_halt_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl1_q[HALT_BIT] |-> !running_i);

  p_tmo_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.expire |=> stat1_q[S1_TMO]);

  p_boot_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.second |=> (stat2_q[S2_SECOND] && stat2_q[S2_BOOT]));

endmodule

// File: rtl/wdt_two_strike.sv
module wdt_two_strike
  import wdt_pkg::*;
#(
  parameter int TICK_CYCLES = 1000,
  parameter int CNT_W       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              smi_en_i,
  input  logic              strap_quiet_i,
  input  logic              no_reboot_i,
  output logic              smi_o,
  output logic              reboot_o
);

  logic             running, tick, load, stop, clr_strike, smi_req, mbox_in_wr;
  logic [CNT_W-1:0] cnt, load_val;
  exp_evt_t         evt;
  logic             smi_q;

  wdt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (running),
    .clear_i (load),
    .tick_o  (tick)
  );

  wdt_expiry_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick),
    .load_i         (load),
    .stop_i         (stop),
    .clr_strike_i   (clr_strike),
    .load_val_i     (load_val),
    .block_reboot_i (strap_quiet_i || no_reboot_i),
    .smi_en_i       (smi_en_i),
    .running_o      (running),
    .cnt_o          (cnt),
    .evt_o          (evt),
    .smi_req_o      (smi_req),
    .reboot_o       (reboot_o)
  );

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (rd_en_i),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .be_i         (be_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .running_i    (running),
    .cnt_i        (cnt),
    .evt_i        (evt),
    .load_o       (load),
    .stop_o       (stop),
    .clr_strike_o (clr_strike),
    .load_val_o   (load_val),
    .mbox_in_wr_o (mbox_in_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else         smi_q <= smi_req || mbox_in_wr;
  end

  assign smi_o = smi_q;

  p_reboot_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |-> !$past(strap_quiet_i || no_reboot_i));

  p_reboot_no_smi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |-> !(smi_o && !$past(mbox_in_wr)));

endmodule

// File: tb/wdt_two_strike_tb.sv
module wdt_two_strike_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        smi_en = 1'b0, strap_quiet = 1'b0, no_reboot = 1'b0;
  logic        smi, reboot;

  int tests = 0, fails = 0;
  int smi_cnt = 0, reb_cnt = 0, cyc = 0;
  int smi0, reb0, t0, t1;
  bit done = 1'b0;
  logic [15:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_two_strike #(.TICK_CYCLES(TICK), .CNT_W(10)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .smi_en_i(smi_en), .strap_quiet_i(strap_quiet), .no_reboot_i(no_reboot),
    .smi_o(smi), .reboot_o(reboot)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (smi)    smi_cnt <= smi_cnt + 1;
    if (reboot) reb_cnt <= reb_cnt + 1;
  end

  // {slot, be, wdata, expected readback}
  localparam logic [37:0] VEC [9] = '{
    {4'd8,  2'b01, 16'h125A, 16'h005A},
    {4'd9,  2'b11, 16'hBEEF, 16'h00EF},
    {4'd10, 2'b01, 16'h00C3, 16'h00C3},
    {4'd5,  2'b11, 16'hA5A5, 16'hA5A5},
    {4'd1,  2'b10, 16'h1200, 16'h1204},
    {4'd1,  2'b01, 16'h0007, 16'h1207},
    {4'd1,  2'b11, 16'h0002, 16'h0002},
    {4'd14, 2'b11, 16'hFFFF, 16'h0000},
    {4'd6,  2'b10, 16'hFF00, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] b, input logic [15:0] v);
    wr_en = 1'b1; addr = a; be = b; wdata = v;
    @(negedge clk);
    wr_en = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    smi0 = smi_cnt; reb0 = reb_cnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    for (int i = 0; i < 11; i++) begin
      rd(4'(i), d);
      chk("R1", d, (i == 1) ? 16'h0004 : (i == 5) ? 16'h0008 : (i == 10) ? 16'h0003 : 16'h0000);
    end
    chk("R1 pulses", {14'd0, smi, reboot}, 16'h0000);

    // R13 byte lanes and unused slots, table walk
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][37:34], VEC[i][33:32], VEC[i][31:16]);
      rd(VEC[i][37:34], d);
      chk("R13", d, VEC[i][15:0]);
    end

    // R9 mailboxes
    do_reset();
    smi_en = 1'b0;
    wr(4'd6, 2'b01, 16'h003C);
    @(negedge clk);
    chk("R9 in smi", 16'(smi_cnt - smi0), 16'd1);
    rd(4'd6, d); chk("R9 in data", d, 16'h003C);
    rd(4'd2, d); chk("R9 in status", d, 16'h0002);
    wr(4'd7, 2'b01, 16'h0055);
    repeat (2) @(negedge clk);
    chk("R9 out no smi", 16'(smi_cnt - smi0), 16'd1);
    rd(4'd7, d); chk("R9 out data", d, 16'h0055);
    rd(4'd2, d); chk("R9 out status", d, 16'h0006);
    chk("R12 smi width", 16'(smi_cnt - smi0), 16'd1);

    // R10 write-one-to-clear
    wr(4'd2, 2'b11, 16'h0002);
    rd(4'd2, d); chk("R10 partial clear", d, 16'h0004);
    wr(4'd2, 2'b11, 16'h0000);
    rd(4'd2, d); chk("R10 zero keeps", d, 16'h0004);
    wr(4'd2, 2'b01, 16'h0004);
    rd(4'd2, d); chk("R10 clear", d, 16'h0000);

    // R2 timeout 1 and 0 never run
    smi_en = 1'b1;
    wr(4'd1, 2'b11, 16'h0001);
    wr(4'd4, 2'b11, 16'h0000);
    t0 = cyc; wait_to(t0 + 40);
    chk("R2 toval1 no smi", 16'(smi_cnt - smi0), 16'd1);
    wr(4'd1, 2'b11, 16'h0000);
    wr(4'd4, 2'b11, 16'h0000);
    t0 = cyc; wait_to(t0 + 40);
    chk("R2 toval0 no smi", 16'(smi_cnt - smi0), 16'd1);
    rd(4'd2, d); chk("R2 no timeout", d, 16'h0000);

    // R3 store when not runnable
    wr(4'd0, 2'b11, 16'h1234);
    rd(4'd0, d); chk("R3 store", d, 16'h1234);

    // R7 lock
    wr(4'd4, 2'b11, 16'h1800);
    rd(4'd4, d); chk("R7 set", d, 16'h1800);
    wr(4'd4, 2'b11, 16'h0000);
    rd(4'd4, d); chk("R7 sticky", d, 16'h1000);
    do_reset();
    rd(4'd4, d); chk("R7 reset", d, 16'h0000);

    // R4 R5 R11 first and second expiry with reboot
    smi_en = 1'b1; strap_quiet = 1'b0; no_reboot = 1'b0;
    wr(4'd1, 2'b11, 16'h0403);
    wr(4'd4, 2'b11, 16'h0000);
    t0 = cyc;
    rd(4'd0, d); chk("R11 live start", d, 16'h0403);
    wait_to(t0 + 5);
    rd(4'd0, d); chk("R11 live tick", d, 16'h0402);
    wait_to(t0 + 11);
    chk("R4 not early", 16'(smi_cnt - smi0), 16'd0);
    wait_to(t0 + 14);
    chk("R4 smi", 16'(smi_cnt - smi0), 16'd1);
    rd(4'd2, d); chk("R4 status", d, 16'h0008);
    wait_to(t0 + 26);
    chk("R5 reboot", 16'(reb_cnt - reb0), 16'd1);
    chk("R5 no smi", 16'(smi_cnt - smi0), 16'd1);
    rd(4'd3, d); chk("R5 status2", d, 16'h0006);
    rd(4'd0, d); chk("R5 stopped", d, 16'h0000);
    wait_to(t0 + 70);
    chk("R12 reboot once", 16'(reb_cnt - reb0), 16'd1);

    // R6 blocked reboot
    do_reset();
    strap_quiet = 1'b1;
    wr(4'd1, 2'b11, 16'h0003);
    wr(4'd4, 2'b11, 16'h0000);
    t0 = cyc;
    wait_to(t0 + 26);
    chk("R6 no reboot", 16'(reb_cnt - reb0), 16'd0);
    chk("R6 smi", 16'(smi_cnt - smi0), 16'd2);
    rd(4'd3, d); chk("R6 status2", d, 16'h0006);
    wait_to(t0 + 38);
    chk("R6 keeps running", 16'(smi_cnt - smi0), 16'd3);
    strap_quiet = 1'b0;

    // R3 reload clears strike count
    do_reset();
    wr(4'd1, 2'b11, 16'h0003);
    wr(4'd4, 2'b11, 16'h0000);
    t0 = cyc;
    wait_to(t0 + 14);
    wr(4'd0, 2'b11, 16'h0000);
    t1 = cyc;
    wait_to(t1 + 14);
    chk("R3 strike cleared", 16'(reb_cnt - reb0), 16'd0);
    rd(4'd3, d); chk("R3 no second", d, 16'h0000);
    wait_to(t1 + 26);
    chk("R3 later reboot", 16'(reb_cnt - reb0), 16'd1);

    // R8 control write stops and restarts
    do_reset();
    wr(4'd1, 2'b11, 16'h0003);
    wr(4'd4, 2'b11, 16'h0000);
    t0 = cyc;
    wait_to(t0 + 6);
    wr(4'd4, 2'b10, 16'h0800);
    wait_to(t0 + 40);
    chk("R8 halted", 16'(smi_cnt - smi0), 16'd0);
    rd(4'd0, d); chk("R8 stored reload", d, 16'h0003);
    wr(4'd4, 2'b11, 16'h0000);
    t1 = cyc;
    wait_to(t1 + 11);
    chk("R8 restart not early", 16'(smi_cnt - smi0), 16'd0);
    wait_to(t1 + 14);
    chk("R8 restart expiry", 16'(smi_cnt - smi0), 16'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule